// File: doc/BRIEF.md
# Radio Power-Mode Sequencer

This block steers a low-power radio core between its operating modes: Off, Hibernate, Doze, Idle, Receive and Transmit. It watches the active-low reset, an active-low wake pin, a receive/transmit enable pin, mode commands from the register interface, a timer-compare wake event and a sequence-finished strobe from the radio datapath. From the current mode it drives the oscillator, SPI, receiver and transmitter enables, a coarse mode code, an "out of idle" flag and a one-cycle interrupt pulse.

Every mode change that needs settling time goes through a warm-up state whose length is a parameter in microseconds, multiplied by the system-clock frequency in MHz. A single shared down-counter times all warm-up states. A testbench can shrink the delays by lowering the frequency and delay parameters.

Top module: `radio_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` is 0 (Off), every enable output is low and `irq` is low. This holds at once, without waiting for a clock edge.
- R2: Once `rst_n` is high, `mode` stays 0 with `osc_en` high. Idle (`mode`=3, `osc_en`=1, `spi_en`=1) is reached on rising edge BOOT_US*CLK_MHZ+1 after the release.
- R3: In Idle, `cmd_valid` with `cmd_code`=1 enters Hibernate (`mode`=1) and `cmd_code`=2 enters Doze (`mode`=2), both on the next edge. Commands are ignored in every other mode.
- R4: In Hibernate, `osc_en` and `spi_en` are low and `tmr_match` has no effect.
- R5: In Hibernate, a low `attn_n` starts a wake-up. `mode` stays 1 with `osc_en` high, and Idle is reached on edge HIB_WAKE_US*CLK_MHZ+1, counting the edge that sampled `attn_n`.
- R6: In Doze (`mode`=2), `osc_en` is high and `spi_en` is low. Either a low `attn_n` or a high `tmr_match` wakes the block. Idle is reached on edge DOZE_WAKE_US*CLK_MHZ+1, counting the sampling edge.
- R7: In Idle, a rising edge of `trx_en` starts a sequence selected by `seq_sel` (0 = Receive, `mode`=4; 1 = Transmit, `mode`=5). `rx_en` or `tx_en` rises on edge TRX_WARM_US*CLK_MHZ+1. A rise of `trx_en` seen outside Idle starts nothing later.
- R8: In Idle with `trx_en` already high, `cmd_code`=3 starts the sequence selected by `seq_sel`. With `trx_en` low this command is ignored.
- R9: A low `trx_en` during warm-up or active Receive/Transmit returns the block to Idle on the next edge, without `irq`.
- R10: `seq_done` in active Receive/Transmit returns the block to Idle on the next edge, with `irq` high for exactly that one cycle. `seq_done` is ignored during warm-up and in Idle.
- R11: `out_of_idle` is high exactly when `mode` is 4 or 5, warm-up included.
- R12: `rx_en` and `tx_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; holds the block in Off |
| attn_n | input | 1 | Active-low wake request from Hibernate or Doze |
| trx_en | input | 1 | Sequence enable: rising edge starts, low level forces Idle |
| seq_sel | input | 1 | Sequence choice: 0 receive, 1 transmit |
| cmd_valid | input | 1 | Mode command strobe |
| cmd_code | input | 2 | 1 hibernate, 2 doze, 3 start sequence, 0 no-op |
| tmr_match | input | 1 | Timer-compare wake event for Doze |
| seq_done | input | 1 | Radio datapath finished the active sequence |
| osc_en | output | 1 | Reference oscillator enable |
| spi_en | output | 1 | Register interface enable |
| rx_en | output | 1 | Receiver active (after warm-up) |
| tx_en | output | 1 | Transmitter active (after warm-up) |
| out_of_idle | output | 1 | High in Receive/Transmit including warm-up |
| irq | output | 1 | One-cycle pulse when a sequence completes |
| mode | output | 3 | 0 Off, 1 Hibernate, 2 Doze, 3 Idle, 4 Receive, 5 Transmit |

## Verification
The case hardest to reach from the ports is a `trx_en` rise that the block must forget. The level has to rise while the block sleeps and then still be high once Idle is reached. Only then does a register start command, rather than the pin, begin a sequence. The stimulus raises `trx_en` inside Hibernate, wakes the block and checks that Idle holds. It then issues the start command. The random phase keeps `trx_en` high after completed sequences, so command-started sequences occur repeatedly. The same phase mixes in aborts during warm-up and completion strobes during warm-up.

// File: rtl/radio_mode_pkg.sv
package radio_mode_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_BOOT,
        ST_IDLE,
        ST_HIB,
        ST_HIB_WAKE,
        ST_DOZE,
        ST_DOZE_WAKE,
        ST_RX_WARM,
        ST_RX,
        ST_TX_WARM,
        ST_TX
    } rmc_state_e;

    localparam logic [1:0] CMD_NOP  = 2'd0;
    localparam logic [1:0] CMD_HIB  = 2'd1;
    localparam logic [1:0] CMD_DOZE = 2'd2;
    localparam logic [1:0] CMD_SEQ  = 2'd3;

    localparam logic [2:0] MODE_OFF  = 3'd0;
    localparam logic [2:0] MODE_HIB  = 3'd1;
    localparam logic [2:0] MODE_DOZE = 3'd2;
    localparam logic [2:0] MODE_IDLE = 3'd3;
    localparam logic [2:0] MODE_RX   = 3'd4;
    localparam logic [2:0] MODE_TX   = 3'd5;

    typedef struct packed {
        logic       osc_en;
        logic       spi_en;
        logic       rx_en;
        logic       tx_en;
        logic       out_of_idle;
        logic [2:0] mode;
    } rmc_out_t;

    typedef struct packed {
        rmc_state_e st;
        logic       irq;
    } rmc_reg_t;

endpackage

// File: rtl/rmc_delay_ctr.sv
module rmc_delay_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R2
    ctr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/rmc_rise_det.sv
module rmc_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic lvl_d, lvl_q;

    always_comb lvl_d = din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign rise = din & ~lvl_q;
endmodule

// File: rtl/rmc_mode_decode.sv
module rmc_mode_decode
    import radio_mode_pkg::*;
(
    input  rmc_state_e st,
    output rmc_out_t   outs
);
    always_comb begin
        outs = '0;
        unique case (st)
            ST_OFF:       outs.mode = MODE_OFF;
            ST_BOOT:      begin outs.mode = MODE_OFF;  outs.osc_en = 1'b1; end
            ST_IDLE:      begin outs.mode = MODE_IDLE; outs.osc_en = 1'b1; outs.spi_en = 1'b1; end
            ST_HIB:       outs.mode = MODE_HIB;
            ST_HIB_WAKE:  begin outs.mode = MODE_HIB;  outs.osc_en = 1'b1; end
            ST_DOZE,
            ST_DOZE_WAKE: begin outs.mode = MODE_DOZE; outs.osc_en = 1'b1; end
            ST_RX_WARM,
            ST_RX: begin
                outs.mode        = MODE_RX;
                outs.osc_en      = 1'b1;
                outs.spi_en      = 1'b1;
                outs.out_of_idle = 1'b1;
                outs.rx_en       = (st == ST_RX);
            end
            ST_TX_WARM,
            ST_TX: begin
                outs.mode        = MODE_TX;
                outs.osc_en      = 1'b1;
                outs.spi_en      = 1'b1;
                outs.out_of_idle = 1'b1;
                outs.tx_en       = (st == ST_TX);
            end
            default:      outs.mode = MODE_OFF;
        endcase
    end
endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
    import radio_mode_pkg::*;
#(
    parameter int CLK_MHZ      = 16,
    parameter int BOOT_US      = 25000,
    parameter int HIB_WAKE_US  = 20000,
    parameter int DOZE_WAKE_US = 300,
    parameter int TRX_WARM_US  = 144
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       attn_n,
    input  logic       trx_en,
    input  logic       seq_sel,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       tmr_match,
    input  logic       seq_done,
    output logic       osc_en,
    output logic       spi_en,
    output logic       rx_en,
    output logic       tx_en,
    output logic       out_of_idle,
    output logic       irq,
    output logic [2:0] mode
);
    localparam int BOOT_CYC = BOOT_US * CLK_MHZ;
    localparam int HIB_CYC  = HIB_WAKE_US * CLK_MHZ;
    localparam int DOZE_CYC = DOZE_WAKE_US * CLK_MHZ;
    localparam int TRX_CYC  = TRX_WARM_US * CLK_MHZ;
    localparam int MAX_AB   = (BOOT_CYC > HIB_CYC) ? BOOT_CYC : HIB_CYC;
    localparam int MAX_CD   = (DOZE_CYC > TRX_CYC) ? DOZE_CYC : TRX_CYC;
    localparam int MAX_CYC  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW       = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] BOOT_LD = CW'(BOOT_CYC - 1);
    localparam logic [CW-1:0] HIB_LD  = CW'(HIB_CYC - 1);
    localparam logic [CW-1:0] DOZE_LD = CW'(DOZE_CYC - 1);
    localparam logic [CW-1:0] TRX_LD  = CW'(TRX_CYC - 1);

    rmc_reg_t      reg_d, reg_q;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          expired;
    logic          trx_rise;
    rmc_out_t      outs;

    rmc_delay_ctr #(.W(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    rmc_rise_det u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trx_en),
        .rise  (trx_rise)
    );

    rmc_mode_decode u_dec (
        .st   (reg_q.st),
        .outs (outs)
    );

    always_comb begin
        reg_d     = reg_q;
        reg_d.irq = 1'b0;
        ld        = 1'b0;
        ld_val    = '0;
        unique case (reg_q.st)
            ST_OFF: begin
                reg_d.st = ST_BOOT;
                ld       = 1'b1;
                ld_val   = BOOT_LD;
            end
            ST_BOOT: if (expired) reg_d.st = ST_IDLE;
            ST_IDLE: begin
                if (trx_rise || (cmd_valid && cmd_code == CMD_SEQ && trx_en)) begin
                    reg_d.st = seq_sel ? ST_TX_WARM : ST_RX_WARM;
                    ld       = 1'b1;
                    ld_val   = TRX_LD;
                end else if (cmd_valid && cmd_code == CMD_HIB) begin
                    reg_d.st = ST_HIB;
                end else if (cmd_valid && cmd_code == CMD_DOZE) begin
                    reg_d.st = ST_DOZE;
                end
            end
            ST_HIB: if (!attn_n) begin
                reg_d.st = ST_HIB_WAKE;
                ld       = 1'b1;
                ld_val   = HIB_LD;
            end
            ST_HIB_WAKE:  if (expired) reg_d.st = ST_IDLE;
            ST_DOZE: if (!attn_n || tmr_match) begin
                reg_d.st = ST_DOZE_WAKE;
                ld       = 1'b1;
                ld_val   = DOZE_LD;
            end
            ST_DOZE_WAKE: if (expired) reg_d.st = ST_IDLE;
            ST_RX_WARM: begin
                if (!trx_en)      reg_d.st = ST_IDLE;
                else if (expired) reg_d.st = ST_RX;
            end
            ST_TX_WARM: begin
                if (!trx_en)      reg_d.st = ST_IDLE;
                else if (expired) reg_d.st = ST_TX;
            end
            ST_RX,
            ST_TX: begin
                if (!trx_en) begin
                    reg_d.st = ST_IDLE;
                end else if (seq_done) begin
                    reg_d.st  = ST_IDLE;
                    reg_d.irq = 1'b1;
                end
            end
            default: reg_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '{st: ST_OFF, irq: 1'b0};
        else        reg_q <= reg_d;
    end

    assign osc_en      = outs.osc_en;
    assign spi_en      = outs.spi_en;
    assign rx_en       = outs.rx_en;
    assign tx_en       = outs.tx_en;
    assign out_of_idle = outs.out_of_idle;
    assign mode        = outs.mode;
    assign irq         = reg_q.irq;

    // R12
    rx_tx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en && tx_en));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(rx_en || tx_en) && mode == MODE_IDLE));

    // R9
    force_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_of_idle && !trx_en) |=> (mode == MODE_IDLE && !irq));

    // R3
    hib_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_HIB && mode != MODE_IDLE) |=> (mode != MODE_HIB));

    // R4
    hib_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HIB) |-> !spi_en);

    // R11
    ooi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_idle |-> (mode == MODE_RX || mode == MODE_TX));
endmodule

// File: tb/sim_radio_mode_ctrl.sv
`timescale 1ns/1ps
module sim_radio_mode_ctrl;
    localparam int MHZ = 1;
    localparam int BT  = 12;
    localparam int HW  = 9;
    localparam int DW  = 5;
    localparam int TW  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       attn_n = 1'b1;
    logic       trx_en = 1'b0;
    logic       seq_sel = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_code = 2'd0;
    logic       tmr_match = 1'b0;
    logic       seq_done = 1'b0;
    logic       osc_en, spi_en, rx_en, tx_en, out_of_idle, irq;
    logic [2:0] mode;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    radio_mode_ctrl #(
        .CLK_MHZ(MHZ), .BOOT_US(BT), .HIB_WAKE_US(HW),
        .DOZE_WAKE_US(DW), .TRX_WARM_US(TW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .trx_en(trx_en),
        .seq_sel(seq_sel), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .tmr_match(tmr_match), .seq_done(seq_done), .osc_en(osc_en),
        .spi_en(spi_en), .rx_en(rx_en), .tx_en(tx_en),
        .out_of_idle(out_of_idle), .irq(irq), .mode(mode)
    );

    function automatic int seq_mode(input bit sel);
        return sel ? 5 : 4;
    endfunction

    function automatic int wake_edges(input int us);
        return us * MHZ;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] code);
        cmd_valid = 1'b1;
        cmd_code  = code;
        tick(1);
        cmd_valid = 1'b0;
        cmd_code  = 2'd0;
    endtask

    task automatic boot_seq();
        rst_n = 1'b1;
        tick(1);
        chk("R2", "boot mode", int'(mode), 0);
        chk("R2", "boot osc", int'(osc_en), 1);
        tick(wake_edges(BT) - 1);
        chk("R2", "mode before idle", int'(mode), 0);
        tick(1);
        chk("R2", "idle mode", int'(mode), 3);
        chk("R2", "idle spi", int'(spi_en), 1);
    endtask

    task automatic do_hib();
        send_cmd(2'd1);
        chk("R3", "hib entry", int'(mode), 1);
        chk("R4", "hib osc", int'(osc_en), 0);
        chk("R4", "hib spi", int'(spi_en), 0);
        tmr_match = 1'b1;
        tick(1);
        tmr_match = 1'b0;
        chk("R4", "tmr ignored", int'(mode), 1);
        send_cmd(2'd2);
        chk("R3", "cmd ignored in hib", int'(mode), 1);
        attn_n = 1'b0;
        tick(1);
        attn_n = 1'b1;
        chk("R5", "wake mode", int'(mode), 1);
        chk("R5", "wake osc", int'(osc_en), 1);
        tick(wake_edges(HW) - 1);
        chk("R5", "still waking", int'(mode), 1);
        tick(1);
        chk("R5", "idle after wake", int'(mode), 3);
    endtask

    task automatic do_doze(input bit by_tmr);
        send_cmd(2'd2);
        chk("R3", "doze entry", int'(mode), 2);
        chk("R6", "doze osc", int'(osc_en), 1);
        chk("R6", "doze spi", int'(spi_en), 0);
        if (by_tmr) tmr_match = 1'b1; else attn_n = 1'b0;
        tick(1);
        tmr_match = 1'b0;
        attn_n    = 1'b1;
        chk("R6", "doze waking", int'(mode), 2);
        tick(wake_edges(DW) - 1);
        chk("R6", "doze still waking", int'(mode), 2);
        tick(1);
        chk("R6", "idle after doze", int'(mode), 3);
    endtask

    // ending: 0 completes, 1 aborts in warm-up, 2 aborts while active
    task automatic do_seq(input bit sel, input int ending);
        seq_sel = sel;
        if (trx_en) begin
            send_cmd(2'd3);
        end else begin
            trx_en = 1'b1;
            tick(1);
        end
        chk("R7", "warm mode", int'(mode), seq_mode(sel));
        chk("R11", "warm out_of_idle", int'(out_of_idle), 1);
        chk("R7", "warm rx/tx off", int'(rx_en | tx_en), 0);
        if (ending == 1) begin
            trx_en = 1'b0;
            tick(1);
            chk("R9", "abort warm mode", int'(mode), 3);
            chk("R9", "abort warm irq", int'(irq), 0);
            chk("R11", "abort warm ooi", int'(out_of_idle), 0);
            return;
        end
        seq_done = 1'b1;
        tick(wake_edges(TW) - 1);
        chk("R10", "done ignored in warm", int'(mode), seq_mode(sel));
        chk("R7", "still warming", int'(rx_en | tx_en), 0);
        tick(1);
        seq_done = 1'b0;
        chk("R7", "rx_en", int'(rx_en), sel ? 0 : 1);
        chk("R7", "tx_en", int'(tx_en), sel ? 1 : 0);
        chk("R12", "exclusive", int'(rx_en & tx_en), 0);
        if (ending == 2) begin
            trx_en = 1'b0;
            tick(1);
            chk("R9", "abort active mode", int'(mode), 3);
            chk("R9", "abort active irq", int'(irq), 0);
            return;
        end
        seq_done = 1'b1;
        tick(1);
        seq_done = 1'b0;
        chk("R10", "done mode", int'(mode), 3);
        chk("R10", "done irq", int'(irq), 1);
        chk("R11", "done ooi", int'(out_of_idle), 0);
        tick(1);
        chk("R10", "irq single pulse", int'(irq), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #750000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2741));
        tick(3);
        chk("R1", "reset mode", int'(mode), 0);
        chk("R1", "reset osc", int'(osc_en), 0);
        chk("R1", "reset spi", int'(spi_en), 0);
        chk("R1", "reset irq", int'(irq), 0);
        boot_seq();

        // R10: seq_done in Idle has no effect
        seq_done = 1'b1;
        tick(1);
        seq_done = 1'b0;
        chk("R10", "done in idle mode", int'(mode), 3);
        chk("R10", "done in idle irq", int'(irq), 0);

        // R8: start command with trx_en low is ignored
        seq_sel = 1'b0;
        send_cmd(2'd3);
        chk("R8", "cmd start w/o enable", int'(mode), 3);

        // R7: trx_en rising inside Hibernate is forgotten
        send_cmd(2'd1);
        trx_en = 1'b1;
        tick(2);
        attn_n = 1'b0;
        tick(1);
        attn_n = 1'b1;
        tick(wake_edges(HW));
        chk("R7", "idle after hib", int'(mode), 3);
        tick(2);
        chk("R7", "stale rise ignored", int'(mode), 3);
        // R8: command start with trx_en held high
        do_seq(1'b1, 0);

        do_hib();
        do_doze(1'b0);
        do_doze(1'b1);
        trx_en = 1'b0;
        tick(1);
        do_seq(1'b0, 0);
        do_seq(1'b0, 2);

        for (int i = 0; i < 40; i++) begin
            int op;
            op = int'($urandom_range(0, 4));
            case (op)
                0: do_hib();
                1: do_doze(1'($urandom_range(0, 1)));
                default: begin
                    if (trx_en && $urandom_range(0, 3) == 0) begin
                        trx_en = 1'b0;
                        tick(1);
                        chk("R9", "drop in idle", int'(mode), 3);
                    end
                    do_seq(1'($urandom_range(0, 1)),
                           ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 2)) : 0);
                end
            endcase
        end

        // R1: reset asserted mid-sequence takes effect at once
        if (!trx_en) begin
            trx_en = 1'b1;
            tick(1);
        end else begin
            seq_sel = 1'b0;
            send_cmd(2'd3);
        end
        tick(wake_edges(TW) + 1);
        rst_n = 1'b0;
        #1;
        chk("R1", "async reset mode", int'(mode), 0);
        chk("R1", "async reset rx/tx", int'(rx_en | tx_en), 0);
        chk("R1", "async reset osc", int'(osc_en), 0);
        trx_en = 1'b0;
        tick(2);
        boot_seq();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule